// File: doc/BRIEF.md
# Scanline mode timing sequencer

This block produces the dot-level timing of a small LCD picture processor. Running from the dot clock, it counts dots across each 456-dot scanline and lines across each 154-line frame. From those counts it derives the current video mode, which is one of four: object search, active drawing, horizontal blank or vertical blank. The drawing phase stretches by a fixed number of dots for every sprite on the line. The sprite count is taken from an input at the first dot of each line.

The same mode decides whether the CPU may reach the two video memories. Picture memory is closed while drawing is in progress. Object attribute memory is closed during both object search and drawing. A closed write gets no write grant, so the memory never sees it. A closed read gets no read grant and returns all ones. That value appears one cycle after the request, which is the same cycle an open read returns memory data. The block also provides two clock enables, one at half and one at a quarter of the dot rate, plus pulses that mark the start of each line and the entry into vertical blank.

The mode comes from a four-state machine whose state code is the mode output. The states are ST_SEARCH (code 2), ST_DRAW (code 3), ST_HBLANK (code 0) and ST_VBLANK (code 1). Its transitions are as follows:

- **Search end:** ST_SEARCH moves to ST_DRAW after the last search dot.
- **Draw end:** ST_DRAW moves to ST_HBLANK after the last drawing dot of the line.
- **Line end, visible:** ST_HBLANK moves to ST_SEARCH at the end of a visible line other than the last one.
- **Frame bottom:** ST_HBLANK moves to ST_VBLANK at the end of the last visible line.
- **Frame wrap:** ST_VBLANK moves to ST_SEARCH at the end of the last line of the frame.

Top module: `lcd_timing_seq`

## Requirements
- R1: `mem_ce` is high on every second dot and `cpu_ce` on every fourth dot. Both are high on the first dot after reset, and `cpu_ce` is never high without `mem_ce`.
- R2: `dot` counts from 0 to 455 and then returns to 0, so each line lasts 456 dots. `line` stays unchanged except when `dot` wraps.
- R3: `line` counts from 0 to 153 and then returns to 0, giving 70224 dots per frame.
- R4: On lines 0 to 143, `mode` is 2 (object search) for dots 0 to 79.
- R5: On lines 0 to 143, `mode` is 3 (drawing) from dot 80 for 168 + 10·n dots. Here n is `sprite_cnt` as sampled at dot 0 of that line, and any value above 10 is treated as 10.
- R6: On lines 0 to 143, `mode` is 0 (horizontal blank) from the end of drawing through dot 455.
- R7: On lines 144 to 153, `mode` is 1 (vertical blank) for every dot.
- R8: `line_start` is high exactly when `dot` is 0. `vblank_start` is high only at line 144, dot 0.
- R9: While `mode` is 3, `vram_wr_ok` and `vram_rd_ok` are low. A picture-memory read requested in that mode makes `vram_rdata` equal 0xFF in the next cycle.
- R10: While `mode` is 2 or 3, `oam_wr_ok` and `oam_rd_ok` are low. An attribute-memory read requested in those modes makes `oam_rdata` equal 0xFF in the next cycle. In modes 0 and 1 both grants follow the requests.
- R11: When a read is not blocked, the read data output in the next cycle is the memory data input. In any cycle not following a blocked read, the read data output passes the memory data through.
- R12: While reset is low and on the first dot after it is released, the outputs read `dot` = 0, `line` = 0 and `mode` = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sprite_cnt | input | 4 | Number of sprites on the coming line, sampled at dot 0 |
| vram_rd | input | 1 | CPU read request to picture memory |
| vram_wr | input | 1 | CPU write request to picture memory |
| vram_mem_rdata | input | 8 | Data from picture memory, one cycle after its read |
| vram_rd_ok | output | 1 | Read passed on to picture memory |
| vram_wr_ok | output | 1 | Write passed on to picture memory |
| vram_rdata | output | 8 | Read data seen by the CPU, 0xFF after a blocked read |
| oam_rd | input | 1 | CPU read request to attribute memory |
| oam_wr | input | 1 | CPU write request to attribute memory |
| oam_mem_rdata | input | 8 | Data from attribute memory, one cycle after its read |
| oam_rd_ok | output | 1 | Read passed on to attribute memory |
| oam_wr_ok | output | 1 | Write passed on to attribute memory |
| oam_rdata | output | 8 | Read data seen by the CPU, 0xFF after a blocked read |
| mode | output | 2 | 0 horizontal blank, 1 vertical blank, 2 object search, 3 drawing |
| line | output | 8 | Current line, 0 to 153 |
| dot | output | 9 | Current dot within the line, 0 to 455 |
| mem_ce | output | 1 | Enable at half the dot rate |
| cpu_ce | output | 1 | Enable at a quarter of the dot rate |
| line_start | output | 1 | High at dot 0 of every line |
| vblank_start | output | 1 | High at dot 0 of line 144 |

## Verification
The bench builds the block with its default parameters: 456 dots per line, 144 visible lines out of 154, and an 80-dot search phase. With these values a full frame plus one further line fits in the run. That means the transitions into vertical blank and back to line 0 are both observed.

The sprite count is driven as the line number modulo 13. This covers drawing lengths for 0, 1, 5 and 10 sprites, the clamp for 11 and 12 sprites, and a drop back to 0 sprites on the next line. Memory requests are placed on both sides of the drawing boundaries, as well as in the search, horizontal-blank and vertical-blank modes.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        ST_HBLANK = 2'd0,
        ST_VBLANK = 2'd1,
        ST_SEARCH = 2'd2,
        ST_DRAW   = 2'd3
    } lcd_mode_e;

endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
    parameter int CPU_DIV = 4,
    parameter int MEM_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic mem_ce,
    output logic cpu_ce
);
    localparam int CW = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CPU_DIV - 1);

    logic [CW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + CW'(1);
        end
    end

    always_comb begin
        mem_ce = ((32'(phase) % MEM_DIV) == 0);
        cpu_ce = (phase == '0);
    end
endmodule

// File: rtl/lcdt_raster.sv
module lcdt_raster
    import lcdt_pkg::*;
#(
    parameter int LINE_DOTS   = 456,
    parameter int VIS_LINES   = 144,
    parameter int ALL_LINES   = 154,
    parameter int SEARCH_DOTS = 80,
    parameter int DRAW_BASE   = 168,
    parameter int DRAW_STEP   = 10,
    parameter int MAX_SPR     = 10,
    parameter int SPR_W       = 4,
    parameter int DOT_W       = 9,
    parameter int LINE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPR_W-1:0]  sprite_cnt,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line,
    output lcd_mode_e         mode,
    output logic              line_start,
    output logic              vblank_start
);
    localparam logic [DOT_W-1:0]  LAST_DOT   = DOT_W'(LINE_DOTS - 1);
    localparam logic [DOT_W-1:0]  SRCH_LAST  = DOT_W'(SEARCH_DOTS - 1);
    localparam logic [DOT_W-1:0]  DRAW_MIN   = DOT_W'(SEARCH_DOTS + DRAW_BASE - 1);
    localparam logic [LINE_W-1:0] LAST_VIS   = LINE_W'(VIS_LINES - 1);
    localparam logic [LINE_W-1:0] FIRST_VBL  = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(ALL_LINES - 1);
    localparam logic [SPR_W-1:0]  SPR_CAP    = SPR_W'(MAX_SPR);

    lcd_mode_e        st, st_nxt;
    logic [SPR_W-1:0] spr_clamped;
    logic [DOT_W-1:0] draw_last;
    logic             at_line_end;

    // Dot and line counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dot  <= '0;
            line <= '0;
        end else if (dot == LAST_DOT) begin
            dot  <= '0;
            line <= (line == LAST_LINE) ? '0 : line + LINE_W'(1);
        end else begin
            dot <= dot + DOT_W'(1);
        end
    end

    // Sprite count sampled at dot 0, clamped, turned into last drawing dot
    assign spr_clamped = (sprite_cnt > SPR_CAP) ? SPR_CAP : sprite_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            draw_last <= DRAW_MIN;
        end else if (dot == '0) begin
            draw_last <= DRAW_MIN + DOT_W'(DRAW_STEP) * DOT_W'(spr_clamped);
        end
    end

    assign at_line_end = (dot == LAST_DOT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_SEARCH;
        end else begin
            st <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_SEARCH: if (dot == SRCH_LAST) st_nxt = ST_DRAW;
            ST_DRAW:   if (dot == draw_last) st_nxt = ST_HBLANK;
            ST_HBLANK: if (at_line_end) begin
                st_nxt = (line == LAST_VIS) ? ST_VBLANK : ST_SEARCH;
            end
            ST_VBLANK: if (at_line_end && line == LAST_LINE) st_nxt = ST_SEARCH;
            default:   st_nxt = ST_SEARCH;
        endcase
    end

    // Outputs
    always_comb begin
        mode         = st;
        line_start   = (dot == '0);
        vblank_start = (dot == '0) && (line == FIRST_VBL);
    end
endmodule

// File: rtl/lcdt_gate.sv
module lcdt_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              block,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic [DATA_W-1:0] rdata
);
    logic masked_q;

    assign rd_ok = rd & ~block;
    assign wr_ok = wr & ~block;

    // A blocked read replaces the data returned one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            masked_q <= 1'b0;
        end else begin
            masked_q <= rd & block;
        end
    end

    assign rdata = masked_q ? {DATA_W{1'b1}} : mem_rdata;
endmodule

// File: rtl/lcd_timing_seq.sv
module lcd_timing_seq
    import lcdt_pkg::*;
#(
    parameter int LINE_DOTS   = 456,
    parameter int VIS_LINES   = 144,
    parameter int ALL_LINES   = 154,
    parameter int SEARCH_DOTS = 80,
    parameter int DRAW_BASE   = 168,
    parameter int DRAW_STEP   = 10,
    parameter int MAX_SPR     = 10,
    parameter int SPR_W       = 4,
    parameter int DATA_W      = 8,
    parameter int CPU_DIV     = 4,
    parameter int MEM_DIV     = 2,
    localparam int DOT_W      = $clog2(LINE_DOTS),
    localparam int LINE_W     = $clog2(ALL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPR_W-1:0]  sprite_cnt,
    input  logic              vram_rd,
    input  logic              vram_wr,
    input  logic [DATA_W-1:0] vram_mem_rdata,
    output logic              vram_rd_ok,
    output logic              vram_wr_ok,
    output logic [DATA_W-1:0] vram_rdata,
    input  logic              oam_rd,
    input  logic              oam_wr,
    input  logic [DATA_W-1:0] oam_mem_rdata,
    output logic              oam_rd_ok,
    output logic              oam_wr_ok,
    output logic [DATA_W-1:0] oam_rdata,
    output logic [1:0]        mode,
    output logic [LINE_W-1:0] line,
    output logic [DOT_W-1:0]  dot,
    output logic              mem_ce,
    output logic              cpu_ce,
    output logic              line_start,
    output logic              vblank_start
);
    lcd_mode_e cur_mode;
    logic      vram_block, oam_block;

    lcdt_clkdiv #(.CPU_DIV(CPU_DIV), .MEM_DIV(MEM_DIV)) i_div (
        .clk(clk), .rst_n(rst_n), .mem_ce(mem_ce), .cpu_ce(cpu_ce)
    );

    lcdt_raster #(
        .LINE_DOTS(LINE_DOTS), .VIS_LINES(VIS_LINES), .ALL_LINES(ALL_LINES),
        .SEARCH_DOTS(SEARCH_DOTS), .DRAW_BASE(DRAW_BASE), .DRAW_STEP(DRAW_STEP),
        .MAX_SPR(MAX_SPR), .SPR_W(SPR_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) i_raster (
        .clk(clk), .rst_n(rst_n), .sprite_cnt(sprite_cnt),
        .dot(dot), .line(line), .mode(cur_mode),
        .line_start(line_start), .vblank_start(vblank_start)
    );

    assign mode       = cur_mode;
    assign vram_block = (cur_mode == ST_DRAW);
    assign oam_block  = (cur_mode == ST_DRAW) || (cur_mode == ST_SEARCH);

    lcdt_gate #(.DATA_W(DATA_W)) i_vram_gate (
        .clk(clk), .rst_n(rst_n), .block(vram_block),
        .rd(vram_rd), .wr(vram_wr), .mem_rdata(vram_mem_rdata),
        .rd_ok(vram_rd_ok), .wr_ok(vram_wr_ok), .rdata(vram_rdata)
    );

    lcdt_gate #(.DATA_W(DATA_W)) i_oam_gate (
        .clk(clk), .rst_n(rst_n), .block(oam_block),
        .rd(oam_rd), .wr(oam_wr), .mem_rdata(oam_mem_rdata),
        .rd_ok(oam_rd_ok), .wr_ok(oam_wr_ok), .rdata(oam_rdata)
    );
endmodule

// File: rtl/lcdt_chk.sv
module lcdt_chk #(
    parameter int LINE_DOTS   = 456,
    parameter int VIS_LINES   = 144,
    parameter int ALL_LINES   = 154,
    parameter int SEARCH_DOTS = 80,
    parameter int DRAW_BASE   = 168,
    parameter int DRAW_STEP   = 10,
    parameter int MAX_SPR     = 10,
    parameter int DATA_W      = 8,
    parameter int DOT_W       = 9,
    parameter int LINE_W      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vram_rd,
    input logic [DATA_W-1:0] vram_mem_rdata,
    input logic              vram_rd_ok,
    input logic              vram_wr_ok,
    input logic [DATA_W-1:0] vram_rdata,
    input logic              oam_rd,
    input logic [DATA_W-1:0] oam_mem_rdata,
    input logic              oam_rd_ok,
    input logic              oam_wr_ok,
    input logic [DATA_W-1:0] oam_rdata,
    input logic [1:0]        mode,
    input logic [LINE_W-1:0] line,
    input logic [DOT_W-1:0]  dot,
    input logic              mem_ce,
    input logic              cpu_ce,
    input logic              line_start
);
    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(LINE_DOTS - 1);
    localparam logic [DOT_W-1:0]  SRCH      = DOT_W'(SEARCH_DOTS);
    localparam logic [DOT_W-1:0]  DRAW_LO   = DOT_W'(SEARCH_DOTS + DRAW_BASE);
    localparam logic [DOT_W-1:0]  DRAW_HI   = DOT_W'(SEARCH_DOTS + DRAW_BASE + DRAW_STEP * MAX_SPR);
    localparam logic [LINE_W-1:0] VIS       = LINE_W'(VIS_LINES);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(ALL_LINES - 1);

    p_cpu_in_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |-> mem_ce);
    p_mem_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce |=> !mem_ce);
    p_dot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dot != LAST_DOT) |=> (dot == $past(dot) + DOT_W'(1)) && $stable(line));
    p_dot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dot == LAST_DOT) |=> (dot == '0) && !$stable(line));
    p_line_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dot == LAST_DOT && line == LAST_LINE) |=> (line == '0));
    p_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (line < VIS && dot < SRCH) |-> (mode == 2'd2));
    p_draw_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line < VIS && dot >= SRCH && dot < DRAW_LO) |-> (mode == 2'd3));
    p_hblank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line < VIS && dot >= DRAW_HI) |-> (mode == 2'd0));
    p_vblank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (line >= VIS) |-> (mode == 2'd1));
    p_lstart_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);
    p_vram_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> !vram_rd_ok && !vram_wr_ok);
    p_vram_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vram_rd && mode == 2'd3) |=> (vram_rdata == {DATA_W{1'b1}}));
    p_oam_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1]) |-> !oam_rd_ok && !oam_wr_ok);
    p_oam_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (oam_rd && mode[1]) |=> (oam_rdata == {DATA_W{1'b1}}));
    p_vram_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vram_rd_ok |=> (vram_rdata == vram_mem_rdata));
    p_oam_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oam_rd_ok |=> (oam_rdata == oam_mem_rdata));
endmodule

bind lcd_timing_seq lcdt_chk #(
    .LINE_DOTS(LINE_DOTS), .VIS_LINES(VIS_LINES), .ALL_LINES(ALL_LINES),
    .SEARCH_DOTS(SEARCH_DOTS), .DRAW_BASE(DRAW_BASE), .DRAW_STEP(DRAW_STEP),
    .MAX_SPR(MAX_SPR), .DATA_W(DATA_W), .DOT_W(DOT_W), .LINE_W(LINE_W)
) i_chk (
    .clk(clk), .rst_n(rst_n),
    .vram_rd(vram_rd), .vram_mem_rdata(vram_mem_rdata),
    .vram_rd_ok(vram_rd_ok), .vram_wr_ok(vram_wr_ok), .vram_rdata(vram_rdata),
    .oam_rd(oam_rd), .oam_mem_rdata(oam_mem_rdata),
    .oam_rd_ok(oam_rd_ok), .oam_wr_ok(oam_wr_ok), .oam_rdata(oam_rdata),
    .mode(mode), .line(line), .dot(dot),
    .mem_ce(mem_ce), .cpu_ce(cpu_ce), .line_start(line_start)
);

// File: tb/test_lcd_timing_seq.sv
`timescale 1ns/1ps
module test_lcd_timing_seq;
    localparam int LD = 456;
    localparam int NV = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sprite_cnt = 4'd0;
    logic       vram_rd = 1'b0, vram_wr = 1'b0, oam_rd = 1'b0, oam_wr = 1'b0;
    logic [7:0] vram_mem_rdata = 8'h5A;
    logic [7:0] oam_mem_rdata  = 8'hC3;
    logic       vram_rd_ok, vram_wr_ok, oam_rd_ok, oam_wr_ok;
    logic [7:0] vram_rdata, oam_rdata;
    logic [1:0] mode;
    logic [7:0] line;
    logic [8:0] dot;
    logic       mem_ce, cpu_ce, line_start, vblank_start;

    int  cyc = 0;
    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_timing_seq i_lcd_timing_seq (
        .clk(clk), .rst_n(rst_n), .sprite_cnt(sprite_cnt),
        .vram_rd(vram_rd), .vram_wr(vram_wr), .vram_mem_rdata(vram_mem_rdata),
        .vram_rd_ok(vram_rd_ok), .vram_wr_ok(vram_wr_ok), .vram_rdata(vram_rdata),
        .oam_rd(oam_rd), .oam_wr(oam_wr), .oam_mem_rdata(oam_mem_rdata),
        .oam_rd_ok(oam_rd_ok), .oam_wr_ok(oam_wr_ok), .oam_rdata(oam_rdata),
        .mode(mode), .line(line), .dot(dot), .mem_ce(mem_ce), .cpu_ce(cpu_ce),
        .line_start(line_start), .vblank_start(vblank_start)
    );

    // Dots elapsed since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Sprite count for the line being entered: line number modulo 13
    always @(negedge clk) sprite_cnt <= 4'((cyc / LD) % 13);

    // {line (absolute, may exceed frame), dot, expected mode}
    localparam logic [18:0] VEC [NV] = '{
        {8'd0,   9'd0,   2'd2}, {8'd0,   9'd79,  2'd2}, {8'd0,   9'd80,  2'd3},
        {8'd0,   9'd247, 2'd3}, {8'd0,   9'd248, 2'd0}, {8'd0,   9'd455, 2'd0},
        {8'd1,   9'd0,   2'd2}, {8'd1,   9'd257, 2'd3}, {8'd1,   9'd258, 2'd0},
        {8'd5,   9'd297, 2'd3}, {8'd5,   9'd298, 2'd0}, {8'd10,  9'd347, 2'd3},
        {8'd10,  9'd348, 2'd0}, {8'd12,  9'd347, 2'd3}, {8'd12,  9'd348, 2'd0},
        {8'd13,  9'd247, 2'd3}, {8'd13,  9'd248, 2'd0}, {8'd143, 9'd455, 2'd0},
        {8'd144, 9'd0,   2'd1}, {8'd144, 9'd100, 2'd1}, {8'd153, 9'd455, 2'd1},
        {8'd154, 9'd0,   2'd2}, {8'd154, 9'd347, 2'd3}, {8'd154, 9'd348, 2'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (dot count %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int target);
        while (cyc != target) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R12: state held during reset
        chk("R12 dot in reset", int'(dot), 0);
        chk("R12 line in reset", int'(line), 0);
        chk("R12 mode in reset", int'(mode), 2);
        rst_n = 1'b1;
    endtask

    // Request all four accesses at one dot, check grants and returned data
    task automatic gate_test(input int at, input bit v_open, input bit o_open);
        wait_to(at);
        vram_rd = 1'b1; vram_wr = 1'b1; oam_rd = 1'b1; oam_wr = 1'b1;
        #1;
        chk("R9 vram_wr_ok", int'(vram_wr_ok), int'(v_open));
        chk("R9 vram_rd_ok", int'(vram_rd_ok), int'(v_open));
        chk("R10 oam_wr_ok", int'(oam_wr_ok), int'(o_open));
        chk("R10 oam_rd_ok", int'(oam_rd_ok), int'(o_open));
        @(negedge clk);
        chk("R9 R11 vram_rdata", int'(vram_rdata), v_open ? 'h5A : 'hFF);
        chk("R10 R11 oam_rdata", int'(oam_rdata), o_open ? 'hC3 : 'hFF);
        vram_rd = 1'b0; vram_wr = 1'b0; oam_rd = 1'b0; oam_wr = 1'b0;
        @(negedge clk);
        chk("R11 vram passthrough", int'(vram_rdata), 'h5A);
        chk("R11 oam passthrough", int'(oam_rdata), 'hC3);
    endtask

    initial begin
        do_reset();
        #1;
        chk("R12 dot after release", int'(dot), 0);
        chk("R1 mem_ce first dot", int'(mem_ce), 1);
        chk("R1 cpu_ce first dot", int'(cpu_ce), 1);

        // Table walk over a frame and one more line
        for (int i = 0; i < NV; i++) begin
            int l, d, m, t;
            l = int'(VEC[i][18:11]);
            d = int'(VEC[i][10:2]);
            m = int'(VEC[i][1:0]);
            t = l * LD + d;
            wait_to(t);
            chk("R4 R5 R6 R7 mode", int'(mode), m);
            chk("R2 dot", int'(dot), d);
            chk("R3 line", int'(line), l % 154);
            chk("R1 mem_ce", int'(mem_ce), (t % 2 == 0) ? 1 : 0);
            chk("R1 cpu_ce", int'(cpu_ce), (t % 4 == 0) ? 1 : 0);
            chk("R8 line_start", int'(line_start), (d == 0) ? 1 : 0);
            chk("R8 vblank_start", int'(vblank_start), (d == 0 && l % 154 == 144) ? 1 : 0);
        end

        // Directed access gating after a fresh reset
        do_reset();
        gate_test(10, 1'b1, 1'b0);               // search: only picture memory open
        gate_test(100, 1'b0, 1'b0);              // drawing: both closed
        gate_test(300, 1'b1, 1'b1);              // horizontal blank: both open
        gate_test(2 * LD + 267, 1'b0, 1'b0);     // last drawing dot, 2 sprites
        gate_test(3 * LD + 278, 1'b1, 1'b1);     // first blank dot, 3 sprites
        gate_test(4 * LD + 79, 1'b1, 1'b0);      // last search dot
        gate_test(144 * LD + 20, 1'b1, 1'b1);    // vertical blank: both open

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule